// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Split Prescaler

This peripheral drives several pulse-width outputs from one shared 8-bit period counter. The counter always covers 256 counts per period. Software sets the period length only through an 8-bit clock divider, which gives 256 possible period lengths for a given input clock. Each channel compares the shared count against its own 8-bit duty value. A channel output is high while the count is below that duty value.

Software reaches the block through a simple single-cycle register port. One control word holds the global run bit and the divider. The divider's upper and lower nibbles sit in two fields of that word that are not next to each other. A second word enables an end-of-period interrupt. The interrupt is sticky and software clears it by writing that same word. The block shadows the divider and the duty values, and loads them into the running logic only at a period boundary, so a period is never cut short or stretched part-way through.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, every PWM output is low and the interrupt line is low.
- R2: The control register is at byte address 0x50. Divider bits [3:0] are written to and read from control bits 3..0. Divider bits [7:4] are written to and read from control bits 14..11. The run bit is control bit 9. Every other control bit reads as zero.
- R3: The duty register of channel c is at byte address 4*c and uses bits 7..0. While the block runs, output c is high exactly when the period count is less than the active duty value of that channel. A duty of 0 keeps the output low for the whole period.
- R4: The period count advances once every (divider+1) input clocks. Starting from an idle block, a channel with duty 255 stays high for 255*(divider+1) clocks after the run bit is set.
- R5: While the block runs, a new divider or duty value written by software reads back at once but reaches the outputs only at the next count wrap (255 to 0).
- R6: The interrupt register is at 0x54. Bit 0 enables the interrupt. Read-only bit 1 shows the pending flag. When the interrupt is enabled, every count wrap sets the flag. The interrupt output equals the flag. While bit 0 is clear, a wrap does not set the flag.
- R7: Any write to 0x54 clears the pending flag. If a write to 0x54 falls in the same cycle as a wrap that sets the flag, the flag stays set.
- R8: While the run bit is clear, the counter and the divider phase are held at zero and all outputs are low. When the run bit is set, the period starts from count 0 with the values already programmed.
- R9: Addresses that hold no register read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, decoded combinationally from reg_addr |
| pwm_o | output | 4 | One PWM output per channel |
| irq_o | output | 1 | Sticky end-of-period interrupt |

## Verification
Two functions can fall in the same clock edge: the hardware setting the pending flag on a count wrap, and a software write to the interrupt register that clears it. The bench reads its reference model to find the cycle just before a wrap and issues the clearing write exactly there. It then expects the flag to remain set, and in a separate step it checks that a clearing write away from any wrap does drop the flag. A second collision works the same way: a divider or duty write that lands on the wrap edge must take effect on the period that begins at once. The cycle-by-cycle model judges this.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Register addresses (byte offsets)
    localparam int ADDR_CTRL    = 'h50;
    localparam int ADDR_IRQ     = 'h54;
    localparam int DUTY_STRIDE  = 4;

    // Control word layout: divider nibbles are split
    localparam int NIB          = 4;
    localparam int PRE_W        = 2 * NIB;
    localparam int CTRL_PLO_LSB = 0;
    localparam int CTRL_RUN_BIT = 9;
    localparam int CTRL_PHI_LSB = 11;

    // Interrupt word layout
    localparam int IRQ_EN_BIT   = 0;
    localparam int IRQ_PEND_BIT = 1;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic                    wrap_i,
    output logic [DW-1:0]           rdata_o,
    output logic                    run_q_o,
    output logic                    run_d_o,
    output logic [PRE_W-1:0]        pre_d_o,
    output logic [NCH-1:0][CW-1:0]  duty_d_o,
    output logic                    irq_o
);

    typedef struct packed {
        logic                   run;
        logic [PRE_W-1:0]       pre;
        logic [NCH-1:0][CW-1:0] duty;
        logic                   ie;
        logic                   flag;
    } regs_t;

    regs_t s_q, s_d;

    logic           wr_ctrl;
    logic           wr_irq;
    logic [NCH-1:0] wr_duty;

    // Next-state computation
    always_comb begin
        wr_ctrl = wr_i && (addr_i == AW'(ADDR_CTRL));
        wr_irq  = wr_i && (addr_i == AW'(ADDR_IRQ));
        for (int c = 0; c < NCH; c++) begin
            wr_duty[c] = wr_i && (addr_i == AW'(DUTY_STRIDE * c));
        end

        s_d = s_q;
        if (wr_ctrl) begin
            s_d.run = wdata_i[CTRL_RUN_BIT];
            s_d.pre = {wdata_i[CTRL_PHI_LSB +: NIB], wdata_i[CTRL_PLO_LSB +: NIB]};
        end
        for (int c = 0; c < NCH; c++) begin
            if (wr_duty[c]) begin
                s_d.duty[c] = wdata_i[CW-1:0];
            end
        end
        if (wr_irq) begin
            s_d.ie = wdata_i[IRQ_EN_BIT];
        end
        // a hardware set outranks a software clear in the same cycle
        if (wrap_i && s_q.ie) begin
            s_d.flag = 1'b1;
        end else if (wr_irq) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Read decode
    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(ADDR_CTRL)) begin
            rdata_o[CTRL_PLO_LSB +: NIB] = s_q.pre[NIB-1:0];
            rdata_o[CTRL_PHI_LSB +: NIB] = s_q.pre[PRE_W-1:NIB];
            rdata_o[CTRL_RUN_BIT]        = s_q.run;
        end else if (addr_i == AW'(ADDR_IRQ)) begin
            rdata_o[IRQ_EN_BIT]   = s_q.ie;
            rdata_o[IRQ_PEND_BIT] = s_q.flag;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr_i == AW'(DUTY_STRIDE * c)) begin
                    rdata_o[CW-1:0] = s_q.duty[c];
                end
            end
        end
    end

    assign run_q_o  = s_q.run;
    assign run_d_o  = s_d.run;
    assign pre_d_o  = s_d.pre;
    assign duty_d_o = s_d.duty;
    assign irq_o    = s_q.flag;

    // R6: an enabled wrap always leaves the flag set
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && s_q.ie) |=> irq_o);

    // R6: the flag only rises after a cycle with the interrupt enabled
    p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(s_q.ie));

    // R7: a clearing write without a colliding wrap drops the flag
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq && !(wrap_i && s_q.ie)) |=> !irq_o);

endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
    import pwm_bank_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q_i,
    input  logic             run_d_i,
    input  logic [PRE_W-1:0] pre_d_i,
    output logic [CW-1:0]    cnt_o,
    output logic             wrap_o,
    output logic             load_o
);

    localparam logic [CW-1:0] CNT_LAST = {CW{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] phase;
        logic [CW-1:0]    cnt;
        logic [PRE_W-1:0] pre;
    } tb_state_t;

    tb_state_t s_q, s_d;
    logic      tick;

    always_comb begin
        tick   = run_q_i && (s_q.phase == s_q.pre);
        wrap_o = tick && (s_q.cnt == CNT_LAST);
        load_o = !run_q_i || wrap_o;

        s_d = s_q;
        if (load_o) begin
            s_d.pre = pre_d_i;
        end
        if (!run_d_i || !run_q_i) begin
            s_d.phase = '0;
            s_d.cnt   = '0;
        end else if (tick) begin
            s_d.phase = '0;
            s_d.cnt   = s_q.cnt + 1'b1;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    // R4: the divider phase never passes the active divider
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q_i |-> (s_q.phase <= s_q.pre));

    // R4: the count moves only on a tick
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q_i && run_d_i && !tick) |=> $stable(s_q.cnt));

    // R5: the active divider changes only at a wrap while running
    p_pre_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q_i && !wrap_o) |=> $stable(s_q.pre));

    // R8: an idle block holds count and phase at zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q_i |-> (s_q.cnt == '0 && s_q.phase == '0));

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          load_i,
    input  logic [CW-1:0] duty_d_i,
    input  logic [CW-1:0] cnt_i,
    output logic          pwm_o
);

    typedef struct packed {
        logic [CW-1:0] duty;
    } ch_state_t;

    ch_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.duty = duty_d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o = run_i && (cnt_i < s_q.duty);

    // R3: a zero duty never drives the output high
    p_zero_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.duty == '0) |-> !pwm_o);

    // R5: the active duty changes only at a load point
    p_duty_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(s_q.duty));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 8,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] pwm_o,
    output logic           irq_o
);

    logic                   run_q;
    logic                   run_d;
    logic [PRE_W-1:0]       pre_d;
    logic [NCH-1:0][CW-1:0] duty_d;
    logic [CW-1:0]          cnt;
    logic                   wrap;
    logic                   load;

    pwm_bank_regs #(
        .NCH (NCH),
        .CW  (CW),
        .AW  (AW),
        .DW  (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .wrap_i   (wrap),
        .rdata_o  (reg_rdata),
        .run_q_o  (run_q),
        .run_d_o  (run_d),
        .pre_d_o  (pre_d),
        .duty_d_o (duty_d),
        .irq_o    (irq_o)
    );

    pwm_bank_timebase #(
        .CW (CW)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_q_i (run_q),
        .run_d_i (run_d),
        .pre_d_i (pre_d),
        .cnt_o   (cnt),
        .wrap_o  (wrap),
        .load_o  (load)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_bank_chan #(
            .CW (CW)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run_q),
            .load_i   (load),
            .duty_d_i (duty_d[c]),
            .cnt_i    (cnt),
            .pwm_o    (pwm_o[c])
        );
    end

    // R8: no output is high while the block is idle
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pwm_o == '0));

endmodule

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] pwm_o;
    logic           irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pwm_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_run, m_pre_st, m_pre_act, m_ph, m_cnt, m_ie, m_flag;
    int m_duty_st [NCH];
    int m_duty_act[NCH];
    int n_run, n_pre, n_ie, n_flag;
    int n_duty[NCH];
    bit m_tick, m_wrap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pre_st = 0; m_pre_act = 0; m_ph = 0; m_cnt = 0;
            m_ie = 0; m_flag = 0;
            for (int c = 0; c < NCH; c++) begin
                m_duty_st[c] = 0; m_duty_act[c] = 0;
            end
        end else begin
            m_tick = (m_run != 0) && (m_ph == m_pre_act);
            m_wrap = m_tick && (m_cnt == 255);
            n_run = m_run; n_pre = m_pre_st; n_ie = m_ie;
            for (int c = 0; c < NCH; c++) n_duty[c] = m_duty_st[c];
            if (reg_wr && reg_addr == 8'h50) begin
                n_run = int'(reg_wdata[9]);
                n_pre = int'(reg_wdata[3:0]) + 16 * int'(reg_wdata[14:11]);
            end
            for (int c = 0; c < NCH; c++)
                if (reg_wr && reg_addr == 8'(4 * c)) n_duty[c] = int'(reg_wdata[7:0]);
            if (reg_wr && reg_addr == 8'h54) n_ie = int'(reg_wdata[0]);
            if (m_wrap && m_ie != 0)                n_flag = 1;
            else if (reg_wr && reg_addr == 8'h54)   n_flag = 0;
            else                                    n_flag = m_flag;
            if (m_run == 0 || m_wrap) begin
                m_pre_act = n_pre;
                for (int c = 0; c < NCH; c++) m_duty_act[c] = n_duty[c];
            end
            if (n_run == 0 || m_run == 0) begin
                m_ph = 0; m_cnt = 0;
            end else if (m_tick) begin
                m_ph = 0; m_cnt = (m_cnt + 1) % 256;
            end else begin
                m_ph = m_ph + 1;
            end
            m_run = n_run; m_pre_st = n_pre; m_ie = n_ie; m_flag = n_flag;
            for (int c = 0; c < NCH; c++) m_duty_st[c] = n_duty[c];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                int e;
                e = (m_run != 0 && m_cnt < m_duty_act[c]) ? 1 : 0;
                check(int'(pwm_o[c]) == e, "R3 channel output", int'(pwm_o[c]), e);
            end
            check(int'(irq_o) == m_flag, "R6 interrupt line", int'(irq_o), m_flag);
        end
    end

    // tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
        @(negedge clk);
    endtask

    task automatic wait_prewrap();
        while (!(m_run != 0 && m_ph == m_pre_act && m_cnt == 255)) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h50, 0, "R1 ctrl reset");
        rd(8'h54, 0, "R1 irq reset");
        for (int c = 0; c < NCH; c++) rd(8'(4 * c), 0, "R1 duty reset");
        check(pwm_o == '0, "R1 outputs low", int'(pwm_o), 0);
        check(irq_o == 1'b0, "R1 irq low", int'(irq_o), 0);

        // R2: control layout, unused bits read zero
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 'h7A0F, "R2 all-ones readback");
        wr(8'h50, 32'h0000_1A05);
        rd(8'h50, 'h1A05, "R2 split divider readback");
        wr(8'h50, 32'h0);
        rd(8'h50, 0, "R2 cleared");

        // R9: unmapped addresses
        wr(8'h40, 32'hFF);
        wr(8'h10, 32'hFF);
        wr(8'h58, 32'hFF);
        rd(8'h40, 0, "R9 unmapped 0x40");
        rd(8'h10, 0, "R9 unmapped 0x10");
        rd(8'h58, 0, "R9 unmapped 0x58");
        rd(8'h00, 0, "R9 duty0 untouched");
        rd(8'h50, 0, "R9 ctrl untouched");

        // R3: duty programming and readback
        wr(8'h00, 32'h0000_0100);   // only bits 7..0 kept -> 0
        wr(8'h04, 32'd1);
        wr(8'h08, 32'd128);
        wr(8'h0C, 32'd255);
        rd(8'h00, 0,   "R3 duty0 width");
        rd(8'h08, 128, "R3 duty2 readback");
        wr(8'h54, 32'd1);
        rd(8'h54, 1, "R6 enable readback");

        // R4/R8: start with divider 1, duty 255 high for 510 clocks
        wr(8'h50, 32'h0000_0201);
        hi = 0;
        while (pwm_o[3] && hi < 2000) begin
            hi++;
            @(negedge clk);
        end
        check(hi == 510, "R4 high time duty 255 divider 1", hi, 510);

        // R5: mid-period writes are shadowed
        while (m_cnt != 10) @(negedge clk);
        wr(8'h04, 32'd200);
        wr(8'h50, 32'h0000_0203);
        rd(8'h50, 'h203, "R5 staged divider readback");
        check(pwm_o[1] == 1'b0, "R5 old duty still active", int'(pwm_o[1]), 0);
        wait_prewrap();
        @(negedge clk);
        check(pwm_o[1] == 1'b1, "R5 new duty after wrap", int'(pwm_o[1]), 1);
        repeat (1100) @(negedge clk);

        // R7: clear away from a wrap
        wr(8'h54, 32'd1);
        check(irq_o == 1'b0, "R7 clear drops flag", int'(irq_o), 0);
        // R7: clear colliding with a wrap keeps the flag
        wait_prewrap();
        wr(8'h54, 32'd1);
        check(irq_o == 1'b1, "R7 set wins over clear", int'(irq_o), 1);
        rd(8'h54, 3, "R6 pending bit");

        // R6: disabled interrupt ignores wraps
        wr(8'h54, 32'd0);
        wait_prewrap();
        @(negedge clk);
        @(negedge clk);
        check(irq_o == 1'b0, "R6 no flag when disabled", int'(irq_o), 0);

        // R5: write landing on the wrap edge applies to the new period
        wait_prewrap();
        wr(8'h08, 32'd2);
        repeat (20) @(negedge clk);

        // R8: stop, reprogram while idle, restart
        wr(8'h50, 32'h0000_0003);
        check(pwm_o == '0, "R8 outputs low when stopped", int'(pwm_o), 0);
        wr(8'h08, 32'd64);
        wr(8'h50, 32'h0000_0200);
        check(pwm_o == 4'b1110, "R8 restart from count 0", int'(pwm_o), 'hE);
        repeat (300) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule